// File: doc/BRIEF.md
# Display Interrupt Status and Masking

This block gathers the event pulses of a multi-channel display controller into two sticky status words and drives a single level interrupt line. The start-of-frame, end-of-frame and branch events come from each channel. Bus errors, FIFO underruns, quick-disable, last-frame-done, read-status and command-done events also arrive. Channel 0 and the controller-wide events land in the primary status word. Channels 1 and up land in the per-channel status word. A control word and a channel mask word hold the mask bits. The interrupt line is high while any unmasked status bit is set.

When an unmasked frame or branch event, or any bus error, arrives while the line is low, the block captures that channel's frame ID word. The ID shows which frame raised the interrupt. If the line is already high, a secondary-interrupt flag is set instead. Software reads and writes the registers through a simple word port. A status bit is cleared by writing 1 to it.

Top module: `disp_irq_agg`

## Requirements
- R1: After reset, every status word, the captured ID, both control words and the interrupt output read as zero.
- R2: Register selects are 0 control, 1 channel mask, 2 primary status, 3 channel status and 4 captured ID. Reads are combinational and the ID register is read-only. The control word keeps bits 26:0 of a write, and the channel mask keeps the bits in 0x3f3f3f3f.
- R3: A control write that takes bit 0 (enable) from 1 to 0 sets the quick-disable flag, primary status bit 7.
- R4: The primary status bits are set as follows. Last-frame-done sets bit 0, channel-0 start of frame bit 1, bus error bit 2, underrun on channel 0 bit 4, underrun on channel 1 bit 5, output underrun bit 6, channel-0 end of frame bit 8, channel-0 branch bit 9, secondary bit 10, read status bit 11 and command done bit 12. Every bit stays set until it is cleared.
- R5: For a channel c of 1 or more, start of frame sets channel status bit c-1, end of frame bit c+7 and branch bit c+15. Underrun on channels 2 and up sets bit c+23.
- R6: The interrupt output is registered and goes high one cycle after any unmasked status bit is set. A status bit is unmasked when its mask bit is clear. Channel status bit n is masked by channel mask bit n. Primary status bit 5 is masked by channel mask bit 24. The other primary bits are masked by control bits: 0 by 3, 1 by 4, 4 by 5, 6 by 21, 7 by 11, 8 by 6, 9 by 20, 11 by 23 and 12 by 24. Bits 2, 3 and 10 never raise the interrupt.
- R7: If an unmasked start-of-frame, end-of-frame or branch event, or any bus error, arrives while the output is low, the captured ID loads that channel's frame ID. When several arrive in one cycle, the lowest channel wins. A masked event captures nothing.
- R8: If such an event arrives while the output is high, the secondary flag is set and the captured ID is kept.
- R9: A bus error sets bit 2 and ORs its channel number into bits 30:28, without any mask check.
- R10: A primary status write clears the bits written as 1 within bits 11:0. Writing 1 to bit 2 also clears bits 30:28.
- R11: A channel status write clears only the bits written as 1 within 0x3e3f3f. All other channel status bits are kept.
- R12: A read-status event sets bit 11. It sets the secondary flag only while the output is high and control bit 23 is clear.
- R13: If an event sets a status bit in the same cycle that a write clears it, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| ev_sof | input | NUM_CH | Start-of-frame pulse per channel |
| ev_eof | input | NUM_CH | End-of-frame pulse per channel |
| ev_branch | input | NUM_CH | Branch-taken pulse per channel |
| ev_underrun | input | NUM_CH | Input underrun pulse per channel |
| ev_ber | input | 1 | Bus error pulse |
| ev_ber_ch | input | CH_W | Channel that took the bus error |
| ev_last_done | input | 1 | Last frame done pulse |
| ev_out_underrun | input | 1 | Output underrun pulse |
| ev_read_status | input | 1 | Panel read status pulse |
| ev_cmd_done | input | 1 | Command done pulse |
| frame_ids | input | NUM_CH*ID_W | Current frame ID of each channel, channel 0 in the low word |
| irq | output | 1 | Level interrupt request |

## Verification
An event and a software clear can fall in the same cycle. The bench provokes this by driving a clear write of a channel status bit together with a new start-of-frame pulse on that channel. It judges the outcome by reading back a set bit, and by checking that the secondary flag is set because the output was high. ID capture and the secondary flag are also exercised against each other. Two channels fire in one cycle while the output is low, and the bench expects the lower channel's ID. Later events while the output is high must leave that ID untouched.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_CHMASK = 3'd1,
        SEL_STAT0  = 3'd2,
        SEL_STAT1  = 3'd3,
        SEL_IRQID  = 3'd4
    } reg_sel_e;

    // primary status bit positions
    localparam int S0_LAST   = 0;
    localparam int S0_SOF0   = 1;
    localparam int S0_BERR   = 2;
    localparam int S0_UND0   = 4;
    localparam int S0_UND1   = 5;
    localparam int S0_OUND   = 6;
    localparam int S0_QDIS   = 7;
    localparam int S0_EOF0   = 8;
    localparam int S0_BR0    = 9;
    localparam int S0_SEC    = 10;
    localparam int S0_RDST   = 11;
    localparam int S0_CMD    = 12;
    localparam int S0_BCH_LO = 28;
    localparam int BCH_W     = 3;

    // control mask bit positions
    localparam int C_EN      = 0;
    localparam int C_M_LAST  = 3;
    localparam int C_M_SOF0  = 4;
    localparam int C_M_UND0  = 5;
    localparam int C_M_EOF0  = 6;
    localparam int C_M_QDIS  = 11;
    localparam int C_M_BR0   = 20;
    localparam int C_M_OUND  = 21;
    localparam int C_M_RDST  = 23;
    localparam int C_M_CMD   = 24;
    localparam int CM_M_UND1 = 24;

    // per-channel field offsets in channel status / mask
    localparam int CH_SOF_OFS = -1;
    localparam int CH_EOF_OFS = 7;
    localparam int CH_BR_OFS  = 15;
    localparam int CH_UND_OFS = 23;

    localparam logic [REG_W-1:0] CTRL_KEEP   = 32'h07ff_ffff;
    localparam logic [REG_W-1:0] CHMASK_KEEP = 32'h3f3f_3f3f;
    localparam logic [REG_W-1:0] ST0_CLR     = 32'h0000_0fff;
    localparam logic [REG_W-1:0] ST1_CLR     = 32'h003e_3f3f;

endpackage

// File: rtl/disp_irq_level.sv
module disp_irq_level
    import disp_irq_pkg::*;
(
    input  logic [REG_W-1:0] ctrl,
    input  logic [REG_W-1:0] chmask,
    input  logic [REG_W-1:0] stat0,
    input  logic [REG_W-1:0] stat1,
    output logic             level
);
    logic p0_hit;
    logic p1_hit;

    always_comb begin
        p0_hit = (stat0[S0_LAST] & ~ctrl[C_M_LAST])
               | (stat0[S0_SOF0] & ~ctrl[C_M_SOF0])
               | (stat0[S0_UND0] & ~ctrl[C_M_UND0])
               | (stat0[S0_UND1] & ~chmask[CM_M_UND1])
               | (stat0[S0_OUND] & ~ctrl[C_M_OUND])
               | (stat0[S0_QDIS] & ~ctrl[C_M_QDIS])
               | (stat0[S0_EOF0] & ~ctrl[C_M_EOF0])
               | (stat0[S0_BR0]  & ~ctrl[C_M_BR0])
               | (stat0[S0_RDST] & ~ctrl[C_M_RDST])
               | (stat0[S0_CMD]  & ~ctrl[C_M_CMD]);
        p1_hit = |(stat1 & ~chmask);
        level  = p0_hit | p1_hit;
    end
endmodule

// File: rtl/disp_irq_idsel.sv
module disp_irq_idsel
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32,
    parameter int CH_W   = 3
) (
    input  logic [REG_W-1:0]       ctrl,
    input  logic [REG_W-1:0]       chmask,
    input  logic [NUM_CH-1:0]      sof,
    input  logic [NUM_CH-1:0]      eof,
    input  logic [NUM_CH-1:0]      branch,
    input  logic                   ber,
    input  logic [CH_W-1:0]        ber_ch,
    input  logic [NUM_CH*ID_W-1:0] frame_ids,
    output logic                   hit,
    output logic [ID_W-1:0]        hit_id
);
    logic [NUM_CH-1:0] cand;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cand
        logic ber_here;
        assign ber_here = ber && (ber_ch == CH_W'(c));
        if (c == 0) begin : g_prim
            assign cand[c] = (sof[c]    & ~ctrl[C_M_SOF0])
                           | (eof[c]    & ~ctrl[C_M_EOF0])
                           | (branch[c] & ~ctrl[C_M_BR0])
                           | ber_here;
        end else begin : g_chan
            assign cand[c] = (sof[c]    & ~chmask[c + CH_SOF_OFS])
                           | (eof[c]    & ~chmask[c + CH_EOF_OFS])
                           | (branch[c] & ~chmask[c + CH_BR_OFS])
                           | ber_here;
        end
    end

    // lowest channel wins: scan downwards so the last hit is the lowest
    always_comb begin
        hit    = 1'b0;
        hit_id = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit    = 1'b1;
                hit_id = frame_ids[i*ID_W +: ID_W];
            end
        end
    end
endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [2:0]             bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    output logic [REG_W-1:0]       bus_rdata,
    input  logic [NUM_CH-1:0]      ev_sof,
    input  logic [NUM_CH-1:0]      ev_eof,
    input  logic [NUM_CH-1:0]      ev_branch,
    input  logic [NUM_CH-1:0]      ev_underrun,
    input  logic                   ev_ber,
    input  logic [CH_W-1:0]        ev_ber_ch,
    input  logic                   ev_last_done,
    input  logic                   ev_out_underrun,
    input  logic                   ev_read_status,
    input  logic                   ev_cmd_done,
    input  logic [NUM_CH*ID_W-1:0] frame_ids,
    output logic                   irq
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] chmask;
        logic [REG_W-1:0] stat0;
        logic [REG_W-1:0] stat1;
        logic [ID_W-1:0]  irqid;
        logic             irq;
    } state_t;

    state_t s_d, s_q;

    logic            level;
    logic            id_hit;
    logic [ID_W-1:0] id_val;
    logic            wr_ctrl, wr_chmask, wr_st0, wr_st1;

    assign wr_ctrl   = bus_we && (bus_addr == SEL_CTRL);
    assign wr_chmask = bus_we && (bus_addr == SEL_CHMASK);
    assign wr_st0    = bus_we && (bus_addr == SEL_STAT0);
    assign wr_st1    = bus_we && (bus_addr == SEL_STAT1);

    disp_irq_level u_level (
        .ctrl   (s_q.ctrl),
        .chmask (s_q.chmask),
        .stat0  (s_q.stat0),
        .stat1  (s_q.stat1),
        .level  (level)
    );

    disp_irq_idsel #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W),
        .CH_W   (CH_W)
    ) u_idsel (
        .ctrl      (s_q.ctrl),
        .chmask    (s_q.chmask),
        .sof       (ev_sof),
        .eof       (ev_eof),
        .branch    (ev_branch),
        .ber       (ev_ber),
        .ber_ch    (ev_ber_ch),
        .frame_ids (frame_ids),
        .hit       (id_hit),
        .hit_id    (id_val)
    );

    always_comb begin
        s_d = s_q;

        // software writes first, so same-cycle events win
        if (wr_ctrl) begin
            if (s_q.ctrl[C_EN] && !bus_wdata[C_EN])
                s_d.stat0[S0_QDIS] = 1'b1;
            s_d.ctrl = bus_wdata & CTRL_KEEP;
        end
        if (wr_chmask)
            s_d.chmask = bus_wdata & CHMASK_KEEP;
        if (wr_st0) begin
            s_d.stat0 = s_d.stat0 & ~(bus_wdata & ST0_CLR);
            if (bus_wdata[S0_BERR])
                s_d.stat0[S0_BCH_LO +: BCH_W] = '0;
        end
        if (wr_st1)
            s_d.stat1 = s_d.stat1 & ~(bus_wdata & ST1_CLR);

        // channel 0 events
        if (ev_sof[0])         s_d.stat0[S0_SOF0] = 1'b1;
        if (ev_eof[0])         s_d.stat0[S0_EOF0] = 1'b1;
        if (ev_branch[0])      s_d.stat0[S0_BR0]  = 1'b1;
        if (ev_underrun[0])    s_d.stat0[S0_UND0] = 1'b1;
        if (NUM_CH > 1 && ev_underrun[NUM_CH > 1 ? 1 : 0])
            s_d.stat0[S0_UND1] = 1'b1;

        // channels 1 and up
        for (int i = 1; i < NUM_CH; i++) begin
            if (ev_sof[i])    s_d.stat1[i + CH_SOF_OFS] = 1'b1;
            if (ev_eof[i])    s_d.stat1[i + CH_EOF_OFS] = 1'b1;
            if (ev_branch[i]) s_d.stat1[i + CH_BR_OFS]  = 1'b1;
        end
        for (int i = 2; i < NUM_CH; i++) begin
            if (ev_underrun[i]) s_d.stat1[i + CH_UND_OFS] = 1'b1;
        end

        // controller-wide events
        if (ev_last_done)    s_d.stat0[S0_LAST] = 1'b1;
        if (ev_out_underrun) s_d.stat0[S0_OUND] = 1'b1;
        if (ev_cmd_done)     s_d.stat0[S0_CMD]  = 1'b1;
        if (ev_read_status) begin
            s_d.stat0[S0_RDST] = 1'b1;
            if (s_q.irq && !s_q.ctrl[C_M_RDST])
                s_d.stat0[S0_SEC] = 1'b1;
        end
        if (ev_ber) begin
            s_d.stat0[S0_BERR] = 1'b1;
            s_d.stat0[S0_BCH_LO +: BCH_W] =
                s_d.stat0[S0_BCH_LO +: BCH_W] | BCH_W'(ev_ber_ch);
        end

        // ID capture or secondary flag
        if (id_hit) begin
            if (s_q.irq) s_d.stat0[S0_SEC] = 1'b1;
            else         s_d.irqid         = id_val;
        end

        s_d.irq = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (bus_addr)
            SEL_CTRL:   bus_rdata = s_q.ctrl;
            SEL_CHMASK: bus_rdata = s_q.chmask;
            SEL_STAT0:  bus_rdata = s_q.stat0;
            SEL_STAT1:  bus_rdata = s_q.stat1;
            SEL_IRQID:  bus_rdata = REG_W'(s_q.irqid);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = s_q.irq;

    // assertions
    logic [REG_W-1:0] stat0_q, stat1_q;
    logic [ID_W-1:0]  irqid_q;
    assign stat0_q = s_q.stat0;
    assign stat1_q = s_q.stat1;
    assign irqid_q = s_q.irqid;

    AST_QDIS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && s_q.ctrl[C_EN] && !bus_wdata[C_EN]) |=> stat0_q[S0_QDIS]); // R3

    AST_BERR_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ber |=> (stat0_q[S0_BERR] &&
        ((stat0_q[S0_BCH_LO +: BCH_W] & BCH_W'($past(ev_ber_ch))) == BCH_W'($past(ev_ber_ch))))); // R9

    AST_ID_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irqid_q) |-> !$past(irq)); // R7

    AST_SEC_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0_q[S0_SEC]) |-> $past(irq)); // R8

    AST_ST1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_st1) |-> (($past(stat1_q) & ~stat1_q) == '0)); // R5

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_q == '0 && stat1_q == '0) |=> !irq); // R6
endmodule

// File: tb/disp_irq_agg_tb.sv
module disp_irq_agg_tb;
    localparam int NCH = 7;
    localparam int IDW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ev_sof = '0, ev_eof = '0, ev_branch = '0, ev_underrun = '0;
    logic            ev_ber = 1'b0;
    logic [2:0]      ev_ber_ch = '0;
    logic            ev_last_done = 1'b0, ev_out_underrun = 1'b0;
    logic            ev_read_status = 1'b0, ev_cmd_done = 1'b0;
    logic [NCH*IDW-1:0] frame_ids;
    logic            irq;

    always #2 clk = ~clk;

    disp_irq_agg #(.NUM_CH(NCH), .ID_W(IDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch),
        .ev_underrun(ev_underrun), .ev_ber(ev_ber), .ev_ber_ch(ev_ber_ch),
        .ev_last_done(ev_last_done), .ev_out_underrun(ev_out_underrun),
        .ev_read_status(ev_read_status), .ev_cmd_done(ev_cmd_done),
        .frame_ids(frame_ids), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    event  mon_ev;

    // monitor: pops expected items and compares with the ports
    always @(mon_ev) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        #1 ->mon_ev;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        #1 ->mon_ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_ev();
        ev_sof = '0; ev_eof = '0; ev_branch = '0; ev_underrun = '0;
        ev_ber = 1'b0; ev_last_done = 1'b0; ev_out_underrun = 1'b0;
        ev_read_status = 1'b0; ev_cmd_done = 1'b0;
    endtask

    // caller sets event inputs after a negedge; this holds them for one edge
    task automatic fire();
        @(negedge clk);
        clear_ev();
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) frame_ids[i*IDW +: IDW] = 32'hA000_0000 + i;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_reg(3'd0, 32'h0, "R1 ctrl after reset");
        expect_reg(3'd1, 32'h0, "R1 chmask after reset");
        expect_reg(3'd2, 32'h0, "R1 stat0 after reset");
        expect_reg(3'd3, 32'h0, "R1 stat1 after reset");
        expect_reg(3'd4, 32'h0, "R1 id after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // R2 write masks
        wr(3'd0, 32'hFFFF_FFFF);
        expect_reg(3'd0, 32'h07FF_FFFF, "R2 ctrl keep");
        wr(3'd1, 32'hFFFF_FFFF);
        expect_reg(3'd1, 32'h3F3F_3F3F, "R2 chmask keep");
        wr(3'd4, 32'h1234_5678);
        expect_reg(3'd4, 32'h0, "R2 id read-only");

        // R3 quick disable, masked
        wr(3'd0, 32'h07FF_FFFE);
        expect_reg(3'd2, 32'h0000_0080, "R3 quick-disable flag");
        idle(1);
        expect_irq(1'b0, "R6 masked quick-disable");

        // R6 unmask
        wr(3'd0, 32'h0);
        expect_reg(3'd2, 32'h0000_0080, "R3 no second flag when already off");
        wr(3'd1, 32'h0);
        expect_irq(1'b1, "R6 unmasked quick-disable");
        wr(3'd2, 32'h0000_0080);
        idle(1);
        expect_irq(1'b0, "R10 irq drops after clear");

        // R7 capture, two channels, lowest wins
        ev_sof[3] = 1'b1; ev_sof[5] = 1'b1;
        fire();
        expect_reg(3'd3, 32'h0000_0014, "R5 sof ch3 and ch5 bits");
        expect_reg(3'd4, 32'hA000_0003, "R7 lowest channel id");
        idle(1);
        expect_irq(1'b1, "R6 irq from channel status");

        // R8 secondary while high
        ev_eof[0] = 1'b1;
        fire();
        expect_reg(3'd2, 32'h0000_0500, "R8 eof0 plus secondary");
        expect_reg(3'd4, 32'hA000_0003, "R8 id kept");
        wr(3'd2, 32'h0000_0500);
        wr(3'd3, 32'h0000_0014);
        expect_reg(3'd2, 32'h0, "R10 stat0 cleared");
        idle(1);
        expect_irq(1'b0, "R10 irq low after clears");

        // R7 masked event captures nothing
        wr(3'd1, 32'h0002_0000);
        ev_branch[2] = 1'b1;
        fire();
        expect_reg(3'd3, 32'h0002_0000, "R5 branch ch2 bit 17");
        expect_reg(3'd4, 32'hA000_0003, "R7 masked branch no capture");
        idle(2);
        expect_irq(1'b0, "R6 masked branch");
        wr(3'd3, 32'h0002_0000);
        wr(3'd1, 32'h0);

        // R9 bus errors
        ev_ber = 1'b1; ev_ber_ch = 3'd5;
        fire();
        expect_reg(3'd2, 32'h5000_0004, "R9 ber ch5");
        expect_reg(3'd4, 32'hA000_0005, "R9 ber captures id");
        idle(2);
        expect_irq(1'b0, "R6 ber does not raise irq");
        ev_ber = 1'b1; ev_ber_ch = 3'd6;
        fire();
        expect_reg(3'd2, 32'h7000_0004, "R9 channel field ORs");
        expect_reg(3'd4, 32'hA000_0006, "R9 second ber id");
        wr(3'd2, 32'h0000_0004);
        expect_reg(3'd2, 32'h0, "R10 ber clear wipes field");

        // R13 event and clear in same cycle
        ev_sof[2] = 1'b1;
        fire();
        expect_reg(3'd4, 32'hA000_0002, "R7 sof ch2 id");
        idle(1);
        expect_irq(1'b1, "R6 sof ch2 irq");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h2;
        ev_sof[2] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; clear_ev();
        expect_reg(3'd3, 32'h0000_0002, "R13 set wins over clear");
        expect_reg(3'd2, 32'h0000_0400, "R8 secondary on repeat");
        wr(3'd2, 32'h0000_0400);
        wr(3'd3, 32'h0000_0002);
        idle(1);
        expect_irq(1'b0, "R11 irq low after st1 clear");

        // R12 read status
        ev_read_status = 1'b1;
        fire();
        expect_reg(3'd2, 32'h0000_0800, "R12 rdst no secondary when low");
        idle(1);
        expect_irq(1'b1, "R6 rdst raises irq");
        ev_read_status = 1'b1;
        fire();
        expect_reg(3'd2, 32'h0000_0C00, "R12 rdst secondary when high");
        wr(3'd0, 32'h0080_0000);
        wr(3'd2, 32'h0000_0C00);
        ev_read_status = 1'b1;
        fire();
        expect_reg(3'd2, 32'h0000_0800, "R12 rdst masked flag");
        idle(2);
        expect_irq(1'b0, "R12 masked rdst keeps irq low");
        wr(3'd2, 32'h0000_0800);
        wr(3'd0, 32'h0);

        // R11 non-clearable channel bits
        ev_underrun[3] = 1'b1; ev_branch[1] = 1'b1;
        fire();
        expect_reg(3'd3, 32'h0401_0000, "R5 underrun ch3 and branch ch1");
        expect_reg(3'd4, 32'hA000_0001, "R7 branch ch1 id");
        wr(3'd3, 32'hFFFF_FFFF);
        expect_reg(3'd3, 32'h0401_0000, "R11 clear mask limits");
        expect_irq(1'b1, "R6 irq from kept bits");

        // R4 remaining primary flags
        ev_underrun[0] = 1'b1; ev_underrun[1] = 1'b1;
        ev_last_done = 1'b1; ev_out_underrun = 1'b1; ev_cmd_done = 1'b1;
        fire();
        expect_reg(3'd2, 32'h0000_1071, "R4 primary flag positions");
        expect_reg(3'd3, 32'h0401_0000, "R4 channel status unchanged");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule